// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a parallel-RGB display module up and down in the order the panel needs. When the power request rises, it first switches the panel supply on. After a programmable settling time, and only once the pixel source reports that its data is valid, it opens the pixel data-enable gate. A short programmable delay later it turns the display on. After a long backlight hold-off it starts the backlight, which is pulse-width modulated from an 8-bit brightness value. While the backlight runs, a ready status is high.

When the request falls, the steps are undone in reverse order, with a programmable gap between each step. The steps are: backlight off, display off, pixel gate off, panel supply off. If the request is dropped part way through power-up, the unwind starts from whatever has already been switched on. If the pixel source does not become ready within a maximum window after the panel supply comes on, the block unwinds as well.

All delays are given in microseconds and converted to clock cycles from the clock frequency parameter. Each delay is at least one cycle. In the requirements below these cycle counts are called T_DATA, T_DATA_MAX, T_DISP, T_BL and T_GAP.

Top module: `lcd_power_seq`

## Requirements
- R1: While reset is low, and after reset until the first request, panel_pwr, pix_gate, disp_on, seq_ready and bl_pwm are all 0.
- R2: With pix_rdy high, panel_pwr rises one clock edge after pwr_req is sampled high, and pix_gate rises exactly T_DATA cycles after panel_pwr.
- R3: pix_gate rises on the first edge on which at least T_DATA cycles have passed since panel_pwr rose and pix_rdy is sampled high. If that has not happened after T_DATA_MAX cycles, the block enters the unwind with panel_pwr still high, and panel_pwr falls T_GAP cycles later.
- R4: disp_on rises exactly T_DISP cycles after pix_gate.
- R5: seq_ready rises exactly T_BL cycles after disp_on.
- R6: While seq_ready is high, bl_pwm follows a period of 255 steps of PWM_DIV cycles each, and is high for `duty` steps of each period. The period starts with its high part when the backlight starts. Duty 0 keeps it low and duty 255 keeps it high.
- R7: bl_pwm is never high while seq_ready is low.
- R8: When pwr_req falls while seq_ready is high, seq_ready and bl_pwm fall on the next edge. disp_on falls T_GAP cycles after that, pix_gate T_GAP cycles after disp_on, and panel_pwr T_GAP cycles after pix_gate.
- R9: When pwr_req falls during power-up, the unwind starts on the next edge at the step matching the outputs already on. Each output that is already on falls T_GAP cycles after the one unwound before it.
- R10: Once an unwind has started, it runs to completion even if pwr_req rises again. The block then spends one cycle fully off before restarting power-up.
- R11: At all times pix_gate implies panel_pwr, disp_on implies pix_gate, and seq_ready implies disp_on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req | input | 1 | High requests the panel on, low requests it off |
| pix_rdy | input | 1 | Pixel source reports valid data |
| duty | input | 8 | Backlight brightness, 0 to 255 |
| panel_pwr | output | 1 | Panel supply enable |
| pix_gate | output | 1 | Pixel data-enable gate |
| disp_on | output | 1 | Display-on control |
| bl_pwm | output | 1 | Pulse-width modulated backlight enable |
| seq_ready | output | 1 | High while the backlight stage is running |

## Verification
On every cycle, the assertions check the nesting of the four levels and that the backlight stays dark outside the running stage. They also check that each rising edge comes only after the minimum time spent at the level below, that pixels never open later than the maximum window, and that a dropped request clears the ready status on the next edge. Only the bench's scenarios can show the exact cycle of every edge in both directions. The same holds for the high count per PWM period at several brightness values, the late-ready and timeout paths, unwinding from each intermediate stage, and the single off cycle before a restart.

// File: rtl/lcd_seq_pkg.sv
// Package lcd_seq_pkg
// Shared state encoding and delay conversion helpers for the panel sequencer.
// Assumes delays fit in 31 bits once converted to cycles.
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PANEL,
        ST_DATA,
        ST_DISP,
        ST_RUN,
        ST_DN_BL,
        ST_DN_DISP,
        ST_DN_PANEL
    } seq_state_t;

    // Convert microseconds to clock cycles, never less than one cycle.
    function automatic int us_to_cyc(input int khz, input int us);
        longint t;
        t = (longint'(khz) * longint'(us)) / 1000;
        return (t < 1) ? 1 : int'(t);
    endfunction

    // Larger of two integers.
    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
// Module lcd_seq_timer
// Counts cycles spent in the current sequencer state. It clears on restart
// and saturates at all ones. Assumes restart is high on the cycle before a
// new state begins.
module lcd_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);

    // Elapsed-cycle counter for the current state.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_seq_fsm.sv
// Module lcd_seq_fsm
// Power sequencing state machine. Output levels are decoded from the state
// register only. Assumes all cycle counts are at least 1 and fit in CW bits.
module lcd_seq_fsm
    import lcd_seq_pkg::*;
#(
    parameter int DATA_CYC = 1,
    parameter int DMAX_CYC = 2,
    parameter int DISP_CYC = 1,
    parameter int BL_CYC   = 1,
    parameter int GAP_CYC  = 1,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_req,
    input  logic          pix_rdy,
    input  logic [CW-1:0] t_cnt,
    output logic          t_restart,
    output logic          panel_pwr,
    output logic          pix_gate,
    output logic          disp_on,
    output logic          bl_run
);

    localparam logic [CW-1:0] LIM_DATA = CW'(DATA_CYC - 1);
    localparam logic [CW-1:0] LIM_DMAX = CW'(DMAX_CYC - 1);
    localparam logic [CW-1:0] LIM_DISP = CW'(DISP_CYC - 1);
    localparam logic [CW-1:0] LIM_BL   = CW'(BL_CYC - 1);
    localparam logic [CW-1:0] LIM_GAP  = CW'(GAP_CYC - 1);

    seq_state_t st_q, st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Next-state selection; abort routes follow the stage already reached.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:      if (pwr_req) st_d = ST_PANEL;
            ST_PANEL: begin
                if (!pwr_req)                          st_d = ST_DN_PANEL;
                else if (t_cnt >= LIM_DATA && pix_rdy) st_d = ST_DATA;
                else if (t_cnt >= LIM_DMAX)            st_d = ST_DN_PANEL;
            end
            ST_DATA: begin
                if (!pwr_req)               st_d = ST_DN_DISP;
                else if (t_cnt >= LIM_DISP) st_d = ST_DISP;
            end
            ST_DISP: begin
                if (!pwr_req)             st_d = ST_DN_BL;
                else if (t_cnt >= LIM_BL) st_d = ST_RUN;
            end
            ST_RUN:      if (!pwr_req) st_d = ST_DN_BL;
            ST_DN_BL:    if (t_cnt >= LIM_GAP) st_d = ST_DN_DISP;
            ST_DN_DISP:  if (t_cnt >= LIM_GAP) st_d = ST_DN_PANEL;
            ST_DN_PANEL: if (t_cnt >= LIM_GAP) st_d = ST_OFF;
            default:     st_d = ST_OFF;
        endcase
    end

    assign t_restart = (st_d != st_q);

    // Output levels per state.
    always_comb begin
        panel_pwr = (st_q != ST_OFF);
        pix_gate  = (st_q == ST_DATA) || (st_q == ST_DISP) || (st_q == ST_RUN) ||
                    (st_q == ST_DN_BL) || (st_q == ST_DN_DISP);
        disp_on   = (st_q == ST_DISP) || (st_q == ST_RUN) || (st_q == ST_DN_BL);
        bl_run    = (st_q == ST_RUN);
    end

endmodule

// File: rtl/lcd_bl_pwm.sv
// Module lcd_bl_pwm
// Backlight PWM with 255 steps per period, each step DIV cycles long.
// The period restarts, high part first, whenever en rises.
module lcd_bl_pwm #(
    parameter int DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] duty,
    output logic       pwm
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;
    logic [7:0]    step_q;

    // Prescaler and step counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_q  <= '0;
            step_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q  <= '0;
            step_q <= (step_q == 8'd254) ? 8'd0 : step_q + 8'd1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    // Compare the current step against the duty value.
    always_comb pwm = en && (step_q < duty);

endmodule

// File: rtl/lcd_power_seq.sv
// Module lcd_power_seq
// Top of the display panel power sequencer. It converts microsecond delays
// to cycles and joins the state machine, its state timer and the backlight
// PWM. Assumes pwr_req and pix_rdy are synchronous to clk.
module lcd_power_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_KHZ     = 50000,
    parameter int DATA_US     = 1000,
    parameter int DATA_MAX_US = 100000,
    parameter int DISP_US     = 1,
    parameter int BL_US       = 160000,
    parameter int GAP_US      = 1000,
    parameter int PWM_DIV     = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_req,
    input  logic       pix_rdy,
    input  logic [7:0] duty,
    output logic       panel_pwr,
    output logic       pix_gate,
    output logic       disp_on,
    output logic       bl_pwm,
    output logic       seq_ready
);

    localparam int DATA_CYC = us_to_cyc(CLK_KHZ, DATA_US);
    localparam int DMAX_CYC = max_i(us_to_cyc(CLK_KHZ, DATA_MAX_US), DATA_CYC);
    localparam int DISP_CYC = us_to_cyc(CLK_KHZ, DISP_US);
    localparam int BL_CYC   = us_to_cyc(CLK_KHZ, BL_US);
    localparam int GAP_CYC  = us_to_cyc(CLK_KHZ, GAP_US);
    localparam int MAX_CYC  = max_i(max_i(DMAX_CYC, DISP_CYC), max_i(BL_CYC, GAP_CYC));
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          t_restart;
    logic [CW-1:0] t_cnt;
    logic          bl_run;

    lcd_seq_timer #(.W(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (t_restart),
        .count   (t_cnt)
    );

    lcd_seq_fsm #(
        .DATA_CYC (DATA_CYC),
        .DMAX_CYC (DMAX_CYC),
        .DISP_CYC (DISP_CYC),
        .BL_CYC   (BL_CYC),
        .GAP_CYC  (GAP_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_req   (pwr_req),
        .pix_rdy   (pix_rdy),
        .t_cnt     (t_cnt),
        .t_restart (t_restart),
        .panel_pwr (panel_pwr),
        .pix_gate  (pix_gate),
        .disp_on   (disp_on),
        .bl_run    (bl_run)
    );

    lcd_bl_pwm #(.DIV(PWM_DIV)) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bl_run),
        .duty  (duty),
        .pwm   (bl_pwm)
    );

    assign seq_ready = bl_run;

endmodule

// File: rtl/lcd_power_seq_chk.sv
// Module lcd_power_seq_chk
// Property checker bound to lcd_power_seq. It keeps saturating run-length
// counters of each output level and checks the ordering rules against them.
module lcd_power_seq_chk #(
    parameter int DATA_CYC = 1,
    parameter int DMAX_CYC = 2,
    parameter int DISP_CYC = 1,
    parameter int BL_CYC   = 1
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_req,
    input logic panel_pwr,
    input logic pix_gate,
    input logic disp_on,
    input logic bl_pwm,
    input logic seq_ready
);

    logic [31:0] en_run, de_run, disp_run;

    // Consecutive-cycle counters for each level.
    always_ff @(posedge clk) begin
        if (!rst_n || !panel_pwr) en_run <= '0;
        else if (en_run != 32'hFFFF_FFFF) en_run <= en_run + 32'd1;
        if (!rst_n || !pix_gate) de_run <= '0;
        else if (de_run != 32'hFFFF_FFFF) de_run <= de_run + 32'd1;
        if (!rst_n || !disp_on) disp_run <= '0;
        else if (disp_run != 32'hFFFF_FFFF) disp_run <= disp_run + 32'd1;
    end

    p_gate_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pix_gate |-> panel_pwr);
    p_disp_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on |-> pix_gate);
    p_ready_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ready |-> disp_on);
    p_bl_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bl_pwm |-> seq_ready);
    p_data_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_gate) |-> (en_run >= 32'(DATA_CYC)));
    p_data_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_gate) |-> (en_run <= 32'(DMAX_CYC)));
    p_disp_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_on) |-> (de_run >= 32'(DISP_CYC)));
    p_bl_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_ready) |-> (disp_run >= 32'(BL_CYC)));
    p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_req |=> !seq_ready);

endmodule

bind lcd_power_seq lcd_power_seq_chk #(
    .DATA_CYC (DATA_CYC),
    .DMAX_CYC (DMAX_CYC),
    .DISP_CYC (DISP_CYC),
    .BL_CYC   (BL_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_req   (pwr_req),
    .panel_pwr (panel_pwr),
    .pix_gate  (pix_gate),
    .disp_on   (disp_on),
    .bl_pwm    (bl_pwm),
    .seq_ready (seq_ready)
);

// File: tb/sim_lcd_power_seq.sv
// Scoreboard bench for lcd_power_seq. Driver tasks push expected output
// vectors {panel_pwr, pix_gate, disp_on, seq_ready, bl_pwm} tagged with a
// cycle number. A monitor pops and compares them at the falling edge.
module sim_lcd_power_seq;

    // 1 cycle per microsecond, so every delay below is in cycles.
    localparam int D    = 20;
    localparam int DMAX = 60;
    localparam int DI   = 10;
    localparam int B    = 40;
    localparam int G    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_req = 1'b0;
    logic       pix_rdy = 1'b0;
    logic [7:0] duty = 8'd0;
    logic       panel_pwr, pix_gate, disp_on, bl_pwm, seq_ready;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [4:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    lcd_power_seq #(
        .CLK_KHZ     (1000),
        .DATA_US     (D),
        .DATA_MAX_US (DMAX),
        .DISP_US     (DI),
        .BL_US       (B),
        .GAP_US      (G),
        .PWM_DIV     (1)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_req   (pwr_req),
        .pix_rdy   (pix_rdy),
        .duty      (duty),
        .panel_pwr (panel_pwr),
        .pix_gate  (pix_gate),
        .disp_on   (disp_on),
        .bl_pwm    (bl_pwm),
        .seq_ready (seq_ready)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] outs();
        return {panel_pwr, pix_gate, disp_on, seq_ready, bl_pwm};
    endfunction

    function automatic void check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endfunction

    task automatic push(int at, logic [4:0] exp, string tag);
        item_t it;
        it.at = at;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wait_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: compare queued expectations at their cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.at == cyc) check(it.tag, int'(outs()), int'(it.exp));
            else check({it.tag, " missed"}, -1, int'(it.exp));
        end
    end

    // Raise the request with pix_rdy high and expect each step on time.
    task automatic power_up(logic [7:0] d);
        int c;
        @(negedge clk);
        c = cyc;
        pix_rdy = 1'b1;
        duty = d;
        pwr_req = 1'b1;
        push(c + 1,          5'b10000, "R2 panel on");
        push(c + D,          5'b10000, "R2 gate held");
        push(c + 1 + D,      5'b11000, "R2 gate on");
        push(c + D + DI,     5'b11000, "R4 disp held");
        push(c + 1 + D + DI, 5'b11100, "R4 disp on");
        push(c + D + DI + B, 5'b11100, "R5 ready held, R7 dark");
        push(c + 1 + D + DI + B, {4'b1111, d != 8'd0}, "R5 ready on, R6 first step");
        wait_to(c + 2 + D + DI + B);
    endtask

    // Count PWM highs over one full 255-cycle period.
    task automatic pwm_count(logic [7:0] d, string tag);
        int hi;
        duty = d;
        hi = 0;
        for (int i = 0; i < 255; i++) begin
            @(negedge clk);
            hi += int'(bl_pwm);
        end
        check(tag, hi, int'(d));
    endtask

    initial begin
        int c, p, a, f;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", int'(outs()), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 outputs after reset", int'(outs()), 0);

        // R2 R4 R5 R6: full power-up and brightness sweep
        power_up(8'd64);
        pwm_count(8'd64, "R6 duty 64");
        pwm_count(8'd0, "R6 duty 0");
        pwm_count(8'd255, "R6 duty 255");
        pwm_count(8'd200, "R6 duty 200");
        duty = 8'd100;

        // R8: orderly power-down
        @(negedge clk);
        f = cyc;
        pwr_req = 1'b0;
        push(f + 1,         5'b11100, "R8 backlight off, R7");
        push(f + G,         5'b11100, "R8 disp held");
        push(f + 1 + G,     5'b11000, "R8 disp off");
        push(f + 2 * G,     5'b11000, "R8 gate held");
        push(f + 1 + 2 * G, 5'b10000, "R8 gate off");
        push(f + 3 * G,     5'b10000, "R8 panel held");
        push(f + 1 + 3 * G, 5'b00000, "R8 panel off");
        wait_to(f + 3 * G + 5);

        // R3: pixels ready late, then R9 abort from the data stage
        @(negedge clk);
        c = cyc;
        pix_rdy = 1'b0;
        pwr_req = 1'b1;
        p = c + 1 + D + 10;
        push(c + 1 + D + 5, 5'b10000, "R3 waits for pixels");
        push(p,             5'b10000, "R3 still waiting");
        push(p + 1,         5'b11000, "R3 gate after ready");
        wait_to(p);
        pix_rdy = 1'b1;
        a = p + 4;
        push(a + 1,         5'b11000, "R9 data abort held");
        push(a + G,         5'b11000, "R9 data abort gate held");
        push(a + 1 + G,     5'b10000, "R9 data abort gate off");
        push(a + 1 + 2 * G, 5'b00000, "R9 data abort panel off");
        wait_to(a);
        pwr_req = 1'b0;
        wait_to(a + 2 * G + 5);

        // R3: pixels never ready, timeout unwind
        @(negedge clk);
        c = cyc;
        pix_rdy = 1'b0;
        pwr_req = 1'b1;
        push(c + DMAX,         5'b10000, "R3 before timeout");
        push(c + DMAX + G,     5'b10000, "R3 timeout panel held");
        push(c + 1 + DMAX + G, 5'b00000, "R3 timeout panel off");
        wait_to(c + 2 + DMAX);
        pwr_req = 1'b0;
        wait_to(c + DMAX + G + 5);

        // R9: abort from the display-on stage
        @(negedge clk);
        c = cyc;
        pix_rdy = 1'b1;
        pwr_req = 1'b1;
        a = c + 1 + D + DI + 5;
        push(a,             5'b11100, "R9 in display stage");
        push(a + 1,         5'b11100, "R9 disp abort, no ready");
        push(a + 1 + G,     5'b11000, "R9 disp abort disp off");
        push(a + 1 + 2 * G, 5'b10000, "R9 disp abort gate off");
        push(a + 1 + 3 * G, 5'b00000, "R9 disp abort panel off");
        wait_to(a);
        pwr_req = 1'b0;
        wait_to(a + 3 * G + 5);

        // R10: request returns during power-down
        power_up(8'd128);
        @(negedge clk);
        f = cyc;
        pwr_req = 1'b0;
        push(f + 3 * G,         5'b10000, "R10 unwind continues");
        push(f + 1 + 3 * G,     5'b00000, "R10 one cycle off");
        push(f + 2 + 3 * G,     5'b10000, "R10 restart");
        push(f + 2 + 3 * G + D, 5'b11000, "R10 restart gate on");
        wait_to(f + 3);
        pwr_req = 1'b1;
        wait_to(f + 3 * G + D + 6);
        pwr_req = 1'b0;
        wait_to(cyc + 4 * G + 5);
        check("R1 idle at end", int'(outs()), 0);
        check("scoreboard drained", q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule